// File: doc/BRIEF.md
# OFDM Receive Frame Buffer with Prefix Removal

This block sits in an OFDM receiver between the frame-synchronization detector and the FFT. A frame begins when the detector raises a start strobe together with a valid sample. From that sample on, the block counts valid samples through a frame of four 20-sample symbols.

Each symbol is a 4-sample cyclic prefix followed by 16 useful samples. The block drops the first symbol of the frame entirely, because it only served synchronization. From each of the three symbols that remain, it drops the prefix and writes the 16 useful samples into a 48-word frame memory.

Once the last sample of the frame has been taken, the block streams the three stored symbols to the FFT as 16-sample blocks. Each block is tagged with a last-sample marker and a symbol index. Capture of a new frame is locked out until that readout finishes.

Top module: `ofdm_rx_frame_buf`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and the block waits for a frame start.
- R2: While waiting, a frame begins only on a cycle where both `frame_start` and `in_valid` are high, and that sample is frame position 0. The first 20 valid samples of the frame (positions 0 to 19) never reach the output.
- R3: For each kept symbol s (s = 1, 2, 3), frame positions 20·s to 20·s+3 are dropped. Positions 20·s+4 to 20·s+19 are output in arrival order. All 48 outputs of a frame appear on consecutive cycles, and `out_valid` stays high across them.
- R4: `out_last` is high exactly on the 16th sample of each block, and never without `out_valid`.
- R5: `out_sym` is 0 for the channel-estimation symbol (frame symbol 1), and 1 and 2 for the two payload symbols.
- R6: A cycle with `in_valid` low does not advance the frame position, and its sample is discarded.
- R7: `frame_start` raised while a frame is being captured has no effect, including on the frame's final sample.
- R8: During readout, `frame_start` and valid input samples are ignored. No frame is captured from them.
- R9: While waiting, valid samples without `frame_start`, and a `frame_start` without `in_valid`, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sample | input | 14 | ADC sample |
| in_valid | input | 1 | Sample qualifier |
| frame_start | input | 1 | Frame-start strobe from the synchronizer |
| out_sample | output | 14 | Useful sample for the FFT |
| out_valid | output | 1 | Output sample qualifier |
| out_last | output | 1 | Last sample of a 16-sample block |
| out_sym | output | 2 | Block index: 0 estimation, 1 and 2 payload |

## Verification
Two functions can fall in the same cycle: a fresh start strobe can coincide with the final captured sample of a frame, and it can coincide with any cycle of the readout, including the last one. The bench provokes the first case by raising the strobe on position 79 and at mid-frame. It provokes the second by holding the strobe and valid samples high for the whole readout. Both cases are judged at the ports: exactly 48 outputs must appear, all of them matching the original frame, and no further output may follow.

// File: rtl/ofdm_rx_frame_buf.sv
module ofdm_rx_frame_buf #(
  parameter int SAMPLE_W   = 14,
  parameter int SYM_LEN    = 20,
  parameter int CP_LEN     = 4,
  parameter int FRAME_SYMS = 4,
  localparam int KEEP      = FRAME_SYMS - 1,
  localparam int IDXW      = (KEEP > 1) ? $clog2(KEEP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_valid,
  input  logic                frame_start,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_valid,
  output logic                out_last,
  output logic [IDXW-1:0]     out_sym
);
  localparam int FFT_N = SYM_LEN - CP_LEN;
  localparam int DEPTH = KEEP * FFT_N;
  localparam int OW    = $clog2(SYM_LEN);
  localparam int SW    = $clog2(FRAME_SYMS);
  localparam int FW    = $clog2(FFT_N);
  localparam int AW    = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_READ} state_t;
  state_t st;

  logic [OW-1:0]       off;
  logic [SW-1:0]       sym;
  logic [AW-1:0]       wr_addr, rd_addr;
  logic [FW-1:0]       rd_off;
  logic [IDXW-1:0]     rd_sym;
  logic [SAMPLE_W-1:0] mem [DEPTH];

  wire start     = (st == S_IDLE) && in_valid && frame_start;
  wire take      = (st == S_CAP) && in_valid;
  wire wr_en     = take && (sym != '0) && (off >= OW'(CP_LEN));
  wire sym_end   = (off == OW'(SYM_LEN - 1));
  wire frame_end = take && sym_end && (sym == SW'(FRAME_SYMS - 1));
  wire blk_end   = (rd_off == FW'(FFT_N - 1));
  wire rd_done   = (st == S_READ) && blk_end && (rd_sym == IDXW'(KEEP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      off <= '0;
      sym <= '0;
      wr_addr <= '0;
      rd_addr <= '0;
      rd_off <= '0;
      rd_sym <= '0;
      out_valid <= 1'b0;
      out_last <= 1'b0;
      out_sym <= '0;
    end else begin
      out_valid <= (st == S_READ);
      out_last  <= (st == S_READ) && blk_end;
      out_sym   <= rd_sym;
      case (st)
        S_IDLE: if (start) begin
          st <= S_CAP;
          off <= OW'(1);
          sym <= '0;
          wr_addr <= '0;
        end
        S_CAP: if (take) begin
          if (sym_end) begin
            off <= '0;
            sym <= sym + 1'b1;
          end else begin
            off <= off + 1'b1;
          end
          if (wr_en) wr_addr <= wr_addr + 1'b1;
          if (frame_end) begin
            st <= S_READ;
            rd_addr <= '0;
            rd_off <= '0;
            rd_sym <= '0;
          end
        end
        S_READ: begin
          rd_addr <= rd_addr + 1'b1;
          if (blk_end) begin
            rd_off <= '0;
            rd_sym <= rd_sym + 1'b1;
          end else begin
            rd_off <= rd_off + 1'b1;
          end
          if (rd_done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr[$clog2(DEPTH)-1:0]] <= in_sample;
    out_sample <= mem[rd_addr[$clog2(DEPTH)-1:0]];
  end

  assert_mem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < AW'(DEPTH)));
  assert_block_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  assert_last_qual_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_sym_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sym < IDXW'(KEEP)));
  assert_hold_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAP && !in_valid) |=> ($stable(off) && $stable(sym)));
  assert_cap_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CAP && frame_start && !frame_end) |=> (st == S_CAP));
  assert_read_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ) |=> $stable(wr_addr));
endmodule

// File: tb/sim_ofdm_rx_frame_buf.sv
module sim_ofdm_rx_frame_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] in_sample = '0;
  logic in_valid = 1'b0;
  logic frame_start = 1'b0;
  logic [13:0] out_sample;
  logic out_valid, out_last;
  logic [1:0] out_sym;

  int total = 0;
  int bad = 0;
  int n_out = 0;
  int cyc = 0;
  logic [13:0] got_s [256];
  logic got_l [256];
  logic [1:0] got_y [256];
  int got_c [256];

  always #5 clk = ~clk;

  ofdm_rx_frame_buf u0 (
    .clk(clk), .rst_n(rst_n), .in_sample(in_sample), .in_valid(in_valid),
    .frame_start(frame_start), .out_sample(out_sample), .out_valid(out_valid),
    .out_last(out_last), .out_sym(out_sym));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && n_out < 256) begin
      got_s[n_out] = out_sample;
      got_l[n_out] = out_last;
      got_y[n_out] = out_sym;
      got_c[n_out] = cyc;
      n_out = n_out + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int s, input bit v, input bit f);
    in_sample = 14'(s);
    in_valid = v;
    frame_start = f;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 0, 0);
  endtask

  task automatic send_frame(input int base, input bit gaps, input bit strobes);
    for (int i = 0; i < 80; i++) begin
      if (gaps && (i % 3 == 1)) begin
        put(16383 - i, 0, 0);
        put(16000 - i, 0, 1);
      end
      put(base + i, 1, (i == 0) || (strobes && (i == 40 || i == 79)));
    end
  endtask

  task automatic check_frame(input int base, input string tag);
    chk(n_out == 48, {tag, " R3 count"}, n_out, 48);
    if (n_out == 48) begin
      bit okv = 1, okl = 1, oky = 1, okc = 1;
      int fv = 0, fe = 0;
      for (int k = 0; k < 48; k++) begin
        int s = k / 16;
        int j = k % 16;
        int e = (base + (s + 1) * 20 + 4 + j) & 16'h3FFF;
        if (okv && got_s[k] != 14'(e)) begin okv = 0; fv = got_s[k]; fe = e; end
        if (got_l[k] != (j == 15)) okl = 0;
        if (got_y[k] != 2'(s)) oky = 0;
        if (got_c[k] != got_c[0] + k) okc = 0;
      end
      chk(okv, {tag, " R2 R3 sample order"}, fv, fe);
      chk(okl, {tag, " R4 last marker"}, 0, 1);
      chk(oky, {tag, " R5 symbol index"}, 0, 1);
      chk(okc, {tag, " R3 contiguous"}, 0, 1);
    end
  endtask

  task automatic t_reset;
    chk(out_valid == 0, "reset R1 out_valid", out_valid, 0);
    chk(out_last == 0, "reset R1 out_last", out_last, 0);
  endtask

  task automatic t_idle_noise;
    n_out = 0;
    put(55, 0, 1);
    for (int i = 0; i < 30; i++) put(600 + i, 1, 0);
    idle(120);
    chk(n_out == 0, "idle noise R9", n_out, 0);
  endtask

  task automatic t_basic;
    n_out = 0;
    send_frame(100, 0, 0);
    idle(70);
    check_frame(100, "basic");
  endtask

  task automatic t_gaps;
    n_out = 0;
    send_frame(2000, 1, 0);
    idle(70);
    check_frame(2000, "gaps R6");
  endtask

  task automatic t_strobe_capture;
    n_out = 0;
    send_frame(5000, 0, 1);
    idle(70);
    check_frame(5000, "cap strobe R7");
    idle(50);
    chk(n_out == 48, "cap strobe R7 no second frame", n_out, 48);
  endtask

  task automatic t_strobe_readout;
    n_out = 0;
    send_frame(7000, 0, 0);
    for (int i = 0; i < 48; i++) put(9000 + i, 1, 1);
    idle(150);
    check_frame(7000, "read strobe R8");
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_noise();
    t_basic();
    t_gaps();
    t_strobe_capture();
    t_strobe_readout();
    t_basic();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule